// File: doc/BRIEF.md
# Element-Width Override Vector Lane

This block walks a vector of `vl` elements held in 64-bit registers, one element per clock. The source element width and the destination element width are each picked by their own 2-bit override code. Source elements are unpacked from consecutive registers starting at `src_base`. Each element is combined with a scalar second operand by a move, add, multiply or divide. The result is narrowed to the destination width by truncation or by unsigned saturation. Results are then packed, or zero-extended, into consecutive registers starting at `dst_base`.

The operation is evaluated at the wider of the two element widths, and the result wraps at that width. Narrowing to the destination width happens only after that, so a widening multiply or a narrowing divide keeps its full intermediate value. With both override codes at zero the lane acts as a plain 64-bit scalar operation, writing one register per element.

The controller has three states. IDLE goes to RUN on `start` with a non-zero `vl`, and to DONE on `start` with `vl` equal to zero. RUN handles one element per cycle and goes to DONE after the last element. DONE raises `done` for one cycle and then returns to IDLE.

Top module: `ewv_lane`

## Requirements
- R1: While reset is held, and in IDLE, `wr_en` and `done` are low, even if `start` is high during reset.
- R2: Width codes are 00 = 64 bits, 01 = 8 bits, 10 = 16 bits and 11 = 32 bits, chosen separately for source and destination. Source element i comes from register `src_base + (i*sw)/64`, at bit offset `(i*sw)%64`.
- R3: Destination element i is placed in register `dst_base + (i*dw)/64`, at bit offset `(i*dw)%64`. A register is written once, when its last slot is filled or after the final element. Slots that are not filled read as zero, and no other register is written.
- R4: Op code 00 is a move of the source element, 01 is a + b, 10 is a * b and 11 is a / b, where b is the low sw bits of `scalar_b`. The result is computed at W = max(sw, dw) and wraps modulo 2^W. Division by zero gives all ones at W.
- R5: With `sat` = 0, the stored result is the low dw bits of the W-bit result.
- R6: With `sat` = 1, a W-bit result above 2^dw - 1 is stored as all ones in dw bits. Otherwise it is stored unchanged.
- R7: With both width codes 00, each element is a full 64-bit operation written to its own register.
- R8: One element is handled per cycle. `done` is high exactly in the cycle after the last element's cycle, which is vl+1 cycles after `start` is taken, and it lasts one cycle.
- R9: `vl` = 0 makes no write, and `done` is raised in the cycle after `start`.
- R10: `start` and any change to the other inputs are ignored while RUN or DONE is active. The configuration is latched when `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector operation when idle |
| vl | input | VL_W | Number of elements |
| op | input | 2 | Operation code |
| src_ew | input | 2 | Source width override code |
| dst_ew | input | 2 | Destination width override code |
| sat | input | 1 | 1 = saturate, 0 = truncate |
| src_base | input | AW | First source register |
| dst_base | input | AW | First destination register |
| scalar_b | input | 64 | Second operand |
| rd_addr | output | AW | Register read address |
| rd_data | input | 64 | Register read data, same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | AW | Register write address |
| wr_data | output | 64 | Register write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The following are checked on every cycle:
- `done` never lasts two cycles.
- An idle lane never writes.
- A zero-length request completes in the next cycle without a write.
- A second `start` during a run never drops the lane back to IDLE.
- Every computed result fits the destination width.

The following only show up in the bench's scenarios:
- Unpack and pack positions.
- Evaluation at the wider width, including wrap before saturation.
- Divide-by-zero value.
- Exact latency.
- Which destination registers are left untouched.

// File: rtl/ewv_pkg.sv
package ewv_pkg;
    localparam int REG_BITS = 64;

    typedef enum logic [1:0] {EW_DEF = 2'b00, EW_8 = 2'b01, EW_16 = 2'b10, EW_32 = 2'b11} ew_e;
    typedef enum logic [1:0] {OP_MV = 2'b00, OP_ADD = 2'b01, OP_MUL = 2'b10, OP_DIV = 2'b11} op_e;
    typedef enum logic [1:0] {S_IDLE = 2'b00, S_RUN = 2'b01, S_DONE = 2'b10} state_e;

    function automatic logic [6:0] ew_bits(input logic [1:0] code);
        unique case (ew_e'(code))
            EW_8:    return 7'd8;
            EW_16:   return 7'd16;
            EW_32:   return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

    function automatic logic [REG_BITS-1:0] width_mask(input logic [6:0] bits);
        if (bits >= 7'd64)
            return '1;
        return (64'd1 << bits[5:0]) - 64'd1;
    endfunction
endpackage

// File: rtl/ewv_extract.sv
module ewv_extract
    import ewv_pkg::*;
(
    input  logic [REG_BITS-1:0] reg_word,
    input  logic [5:0]          bit_off,
    input  logic [6:0]          bits,
    output logic [REG_BITS-1:0] elem
);
    always_comb begin
        elem = (reg_word >> bit_off) & width_mask(bits);
    end
endmodule

// File: rtl/ewv_alu.sv
module ewv_alu
    import ewv_pkg::*;
(
    input  logic [REG_BITS-1:0] opa,
    input  logic [REG_BITS-1:0] opb,
    input  op_e                 op,
    input  logic [6:0]          sbits,
    input  logic [6:0]          dbits,
    input  logic                sat,
    output logic [REG_BITS-1:0] res
);
    logic [6:0]          wbits;
    logic [REG_BITS-1:0] raw;
    logic [REG_BITS-1:0] wide;
    logic [REG_BITS-1:0] dmask;

    always_comb begin
        wbits = (sbits > dbits) ? sbits : dbits;
        unique case (op)
            OP_MV:   raw = opa;
            OP_ADD:  raw = opa + opb;
            OP_MUL:  raw = opa * opb;
            OP_DIV:  raw = (opb == '0) ? '1 : opa / opb;
            default: raw = opa;
        endcase
        wide  = raw & width_mask(wbits);
        dmask = width_mask(dbits);
        if (sat && (wide > dmask))
            res = dmask;
        else
            res = wide & dmask;
    end
endmodule

// File: rtl/ewv_lane.sv
module ewv_lane
    import ewv_pkg::*;
#(
    parameter int VL_W = 7,
    parameter int AW   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VL_W-1:0]     vl,
    input  logic [1:0]          op,
    input  logic [1:0]          src_ew,
    input  logic [1:0]          dst_ew,
    input  logic                sat,
    input  logic [AW-1:0]       src_base,
    input  logic [AW-1:0]       dst_base,
    input  logic [REG_BITS-1:0] scalar_b,
    output logic [AW-1:0]       rd_addr,
    input  logic [REG_BITS-1:0] rd_data,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output logic [REG_BITS-1:0] wr_data,
    output logic                done
);
    localparam int PW = VL_W + 7;

    state_e              state_q, state_d;
    logic [VL_W-1:0]     idx_q, vl_q;
    op_e                 op_q;
    logic [1:0]          sew_q, dew_q;
    logic                sat_q;
    logic [AW-1:0]       sbase_q, dbase_q;
    logic [REG_BITS-1:0] b_q, pack_q, pack_next;

    logic [6:0]          sbits, dbits;
    logic [PW-1:0]       spos, dpos;
    logic [REG_BITS-1:0] elem_a, alu_res, dmask;
    logic                last, slot_full, busy;

    assign sbits = ew_bits(sew_q);
    assign dbits = ew_bits(dew_q);
    assign dmask = width_mask(dbits);
    assign spos  = PW'(idx_q) * PW'(sbits);
    assign dpos  = PW'(idx_q) * PW'(dbits);
    assign busy  = (state_q != S_IDLE);

    ewv_extract u_extract (
        .reg_word (rd_data),
        .bit_off  (spos[5:0]),
        .bits     (sbits),
        .elem     (elem_a)
    );

    ewv_alu u_alu (
        .opa   (elem_a),
        .opb   (b_q & width_mask(sbits)),
        .op    (op_q),
        .sbits (sbits),
        .dbits (dbits),
        .sat   (sat_q),
        .res   (alu_res)
    );

    always_comb begin
        last      = (idx_q == vl_q - VL_W'(1));
        slot_full = (({1'b0, dpos[5:0]} + dbits) == 7'd64);
        pack_next = pack_q | (alu_res << dpos[5:0]);
        state_d   = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = (vl == '0) ? S_DONE : S_RUN;
            S_RUN:  if (last)  state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            vl_q    <= '0;
            op_q    <= OP_MV;
            sew_q   <= '0;
            dew_q   <= '0;
            sat_q   <= 1'b0;
            sbase_q <= '0;
            dbase_q <= '0;
            b_q     <= '0;
            pack_q  <= '0;
        end else if (state_q == S_IDLE) begin
            if (start) begin
                idx_q   <= '0;
                vl_q    <= vl;
                op_q    <= op_e'(op);
                sew_q   <= src_ew;
                dew_q   <= dst_ew;
                sat_q   <= sat;
                sbase_q <= src_base;
                dbase_q <= dst_base;
                b_q     <= scalar_b;
                pack_q  <= '0;
            end
        end else if (state_q == S_RUN) begin
            idx_q  <= idx_q + VL_W'(1);
            pack_q <= (slot_full || last) ? '0 : pack_next;
        end
    end

    always_comb begin
        rd_addr = sbase_q + AW'(spos[PW-1:6]);
        wr_addr = dbase_q + AW'(dpos[PW-1:6]);
        wr_data = pack_next;
        wr_en   = (state_q == S_RUN) && (slot_full || last);
        done    = (state_q == S_DONE);
    end
endmodule

// File: rtl/ewv_lane_chk.sv
module ewv_lane_chk #(
    parameter int VL_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [VL_W-1:0]   vl,
    input logic              done,
    input logic              wr_en,
    input logic              busy,
    input logic [63:0]       res,
    input logic [63:0]       dmask
);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);

    a_r9_zero_vl: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vl == '0) |=> (done && !wr_en));

    a_r6_fits_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> ((res & ~dmask) == 64'd0));

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);
endmodule

bind ewv_lane ewv_lane_chk #(.VL_W(VL_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .vl    (vl),
    .done  (done),
    .wr_en (wr_en),
    .busy  (busy),
    .res   (alu_res),
    .dmask (dmask)
);

// File: tb/ewv_lane_tb_top.sv
module ewv_lane_tb_top;
    localparam logic [63:0] MARK = 64'hA5A5_A5A5_A5A5_A5A5;
    localparam int DB = 32;

    typedef struct packed {
        logic [1:0]  sew;
        logic [1:0]  dew;
        logic [1:0]  op;
        logic        sat;
        logic [6:0]  vl;
        logic [63:0] b;
        logic        chk0;
        logic [63:0] exp0;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 2'b00, 2'b00, 1'b0, 7'd8,  64'd0,       1'b1, 64'hFF},               // R2 R3: byte -> 64-bit regs
        '{2'b01, 2'b10, 2'b10, 1'b0, 7'd1,  64'd2,       1'b1, 64'h1FE},              // R4: 255*2 = 510
        '{2'b10, 2'b01, 2'b11, 1'b0, 7'd2,  64'd2,       1'b1, 64'h807F},             // R5: 256/2 = 128, truncation
        '{2'b10, 2'b01, 2'b11, 1'b1, 7'd2,  64'd2,       1'b1, 64'h80FF},             // R6: saturation
        '{2'b00, 2'b00, 2'b01, 1'b0, 7'd1,  64'd1,       1'b1, 64'hF0E1D2C301000300}, // R7: plain 64-bit add
        '{2'b01, 2'b01, 2'b01, 1'b1, 7'd1,  64'h10,      1'b1, 64'h0F},               // R4 R6: wrap at W before saturation
        '{2'b11, 2'b10, 2'b11, 1'b0, 7'd2,  64'd0,       1'b1, 64'hFFFF_FFFF},        // R4: divide by zero
        '{2'b10, 2'b11, 2'b10, 1'b0, 7'd4,  64'd3,       1'b0, 64'd0},
        '{2'b00, 2'b01, 2'b00, 1'b1, 7'd3,  64'd0,       1'b0, 64'd0},
        '{2'b01, 2'b01, 2'b00, 1'b0, 7'd64, 64'd0,       1'b0, 64'd0},
        '{2'b11, 2'b01, 2'b01, 1'b0, 7'd5,  64'h100,     1'b0, 64'd0},
        '{2'b01, 2'b01, 2'b00, 1'b0, 7'd0,  64'd0,       1'b1, MARK},                 // R9: no writes
        '{2'b00, 2'b10, 2'b10, 1'b1, 7'd3,  64'h10000,   1'b0, 64'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n, start, sat, wr_en, done;
    logic [6:0]  vl;
    logic [1:0]  op, sew, dew;
    logic [5:0]  sbase, dbase, rd_addr, wr_addr;
    logic [63:0] scalar_b, rd_data, wr_data;
    logic [63:0] mem [0:63];
    logic [63:0] expv [0:31];
    int          n_chk = 0, n_fail = 0, cyc = 0, lat;

    always #5 clk = ~clk;

    assign rd_data = mem[rd_addr];
    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    ewv_lane dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .op(op),
        .src_ew(sew), .dst_ew(dew), .sat(sat), .src_base(sbase), .dst_base(dbase),
        .scalar_b(scalar_b), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int wb(input logic [1:0] c);
        return (c == 2'b01) ? 8 : (c == 2'b10) ? 16 : (c == 2'b11) ? 32 : 64;
    endfunction

    function automatic logic [63:0] msk(input int w);
        return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    endfunction

    // Independent model of R2-R6: builds expected destination image.
    task automatic model(input vec_t v);
        int sw, dw, w, p, q;
        logic [63:0] a, b, r;
        bit touched [0:31];
        sw = wb(v.sew); dw = wb(v.dew); w = (sw > dw) ? sw : dw;
        for (int k = 0; k < 32; k++) begin expv[k] = MARK; touched[k] = 0; end
        for (int i = 0; i < int'(v.vl); i++) begin
            p = i * sw;
            a = (mem[p / 64] >> (p % 64)) & msk(sw);
            b = v.b & msk(sw);
            case (v.op)
                2'b00: r = a;
                2'b01: r = a + b;
                2'b10: r = a * b;
                default: r = (b == 0) ? {64{1'b1}} : a / b;
            endcase
            r = r & msk(w);
            if (v.sat && r > msk(dw)) r = msk(dw);
            else r = r & msk(dw);
            q = i * dw;
            if (!touched[q / 64]) begin expv[q / 64] = 64'd0; touched[q / 64] = 1; end
            expv[q / 64] = expv[q / 64] | (r << (q % 64));
        end
    endtask

    task automatic preload();
        mem[0] <= 64'hF0E1_D2C3_0100_02FF;
        for (int i = 1; i < DB; i++) mem[i] <= 64'h0F1E_2D3C_4B5A_6978 * 64'(i) + 64'(i * 37);
        for (int i = DB; i < 64; i++) mem[i] <= MARK;
        #1;
    endtask

    task automatic drive(input vec_t v);
        sew = v.sew; dew = v.dew; op = v.op; sat = v.sat; vl = v.vl;
        scalar_b = v.b; sbase = 6'd0; dbase = 6'(DB);
    endtask

    // Starts a run at a negedge; counts negedges until done (R8).
    task automatic run(input vec_t v, input bit hold_start);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        if (hold_start) begin
            op = ~v.op; sew = ~v.sew; dbase = 6'd40; vl = 7'd9; scalar_b = 64'd99;
            @(negedge clk);
            lat = 2;
        end else begin
            lat = 1;
        end
        start = 1'b0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check(lat == int'(v.vl) + 1, "R8 latency", 64'(lat), 64'(int'(v.vl) + 1));
        @(negedge clk);
        check(!done, "R8 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic compare(input int row, input vec_t v);
        int bad;
        bad = -1;
        for (int k = 0; k < 32; k++)
            if (mem[DB + k] !== expv[k] && bad < 0) bad = k;
        if (bad >= 0)
            check(0, $sformatf("R2 R3 R4 R5 R6 R7 image row %0d reg %0d", row, DB + bad),
                  mem[DB + bad], expv[bad]);
        else
            check(1, "image", 64'd0, 64'd0);
        if (v.chk0)
            check(mem[DB] === v.exp0, $sformatf("R4 R5 R6 R7 R9 first reg row %0d", row), mem[DB], v.exp0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b1;
        drive(VECS[0]);
        preload();
        repeat (3) @(negedge clk);
        check(!done, "R1 reset done", 64'(done), 64'd0);
        check(!wr_en, "R1 reset wr_en", 64'(wr_en), 64'd0);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!wr_en && !done, "R1 idle quiet", {62'd0, wr_en, done}, 64'd0);
        check(mem[DB] === MARK, "R1 no write during reset", mem[DB], MARK);

        for (int r = 0; r < NV; r++) begin
            preload();
            model(VECS[r]);
            run(VECS[r], 1'b0);
            compare(r, VECS[r]);
        end

        // R10: start held and inputs changed while running are ignored.
        preload();
        model(VECS[7]);
        run(VECS[7], 1'b1);
        compare(100, VECS[7]);
        check(mem[40] === MARK, "R10 no write at changed base", mem[40], MARK);

        summary();
        $finish;
    end
endmodule